// File: doc/BRIEF.md
# GPIO Register Bank

This block is the software-facing register bank for a bank of 32 general-purpose pins. A simple word-addressed bus with separate read and write strobes, a 7-bit word index and 32-bit data gives access to it. Each per-pin attribute has three addresses: one where writing ones sets bits, one where writing ones clears bits, and one that reads the current bits back. The attributes are PIO ownership, output enable, input filter enable, multi-driver, pull-up, peripheral B select, output-write enable and interrupt mask.

The bank keeps an output data register that can be changed in three ways: a set address, a clear address, and a direct-write address. The direct-write address only affects the bits permitted by the output-write enable mask. The bank also samples the input pins and records a change event for every pin it observes. It combines the masked events into one interrupt line, and reading the event status clears it.

Whether a pin is currently driven from outside is an input to the block. Undriven pins are treated as unknown, and for those pins the pin data register returns the pull-up setting in place of the sampled level.

The following stay outside the bank: glitch filtering, open-drain electrical behaviour, pad drivers and peripheral routing.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, the PIO ownership status reads 0xFFFFFFFF. Every other status word, the output data, the event status and the pin data read zero. `irq` and `pinOut` are low.
- R2: Each attribute has a set word and a clear word. Writing ones to the set word sets exactly those bits of the attribute, and writing ones to the clear word clears exactly those bits. The status word returns the result. The word indices (set/clear/status) are: ownership 0/1/2, output enable 4/5/6, filter 8/9/10, interrupt mask 16/17/18, multi-driver 20/21/22, output-write enable 40/41/42.
- R3: The pull-up attribute has its set and clear words swapped: clear is at word 24, set at word 25, status at word 26.
- R4: Peripheral select uses word 28 to clear bits (select A) and word 29 to set bits (select B). The status reads at word 30.
- R5: Writing ones to word 12 sets the matching bits of the output data register (read at word 14). Writing ones to word 13 clears them. `pinOut` changes only for bits whose output enable is set.
- R6: A write to word 14 replaces only the output data bits, and the `pinOut` bits, that are enabled in the output-write enable mask. All other bits keep their value.
- R7: A pin is eligible when it is PIO-owned and its output enable is clear. On each clock edge, an eligible pin takes `pinValid & pinIn` as its sampled level and becomes known if `pinValid` is set, or unknown if it is clear. Word 15 returns the sampled level for known pins and the pull-up bit for unknown pins. Pins start unknown.
- R8: When the sampled level of an eligible pin changes, its event status bit is set on that edge. Pins that are not eligible neither set event bits nor update their sampled level.
- R9: `irq` is high exactly while at least one event status bit is set together with its interrupt mask bit.
- R10: Reading word 19 returns the event status and clears it on that edge. `irq` is low afterwards unless a new event arrived.
- R11: If a word 19 read and a new change event happen on the same edge, the new event's status bit stays set.
- R12: Reads of unmapped or write-only words return zero. Writes to unmapped or status-only words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 7 | Word index inside the 0x200-byte window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid combinationally while rdEn is high |
| pinIn | input | 32 | Input level of each pin |
| pinValid | input | 32 | Per pin, high when the pin is driven (known state) |
| pinOut | output | 32 | Driven level of each pin |
| pinOe | output | 32 | Output enable of each pin |
| irq | output | 1 | Combined interrupt line |

## Verification
The hardest situation to reach is the collision between a clear-on-read and a fresh pin change on the same clock edge. The bench gets there by driving the read strobe and the toggled pin level in the same half cycle. It then reads the status again, which must show only the new event. A second hard area is pins that are not eligible. The bench makes some pins outputs or hands them to a peripheral, toggles them, and then confirms through the status and pin data words that nothing was recorded for them.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

  localparam int NATTR   = 8;
  localparam int ATTR_IW = $clog2(NATTR);
  localparam int WORD_W  = 7;

  // attribute slots
  localparam int A_PIO  = 0;
  localparam int A_OE   = 1;
  localparam int A_FILT = 2;
  localparam int A_IMSK = 3;
  localparam int A_MDRV = 4;
  localparam int A_PULL = 5;
  localparam int A_PSEL = 6;
  localparam int A_OWEN = 7;

  localparam logic [WORD_W-1:0] SET_WORD  [NATTR] = '{7'd0, 7'd4, 7'd8, 7'd16, 7'd20, 7'd25, 7'd29, 7'd40};
  localparam logic [WORD_W-1:0] CLR_WORD  [NATTR] = '{7'd1, 7'd5, 7'd9, 7'd17, 7'd21, 7'd24, 7'd28, 7'd41};
  localparam logic [WORD_W-1:0] STAT_WORD [NATTR] = '{7'd2, 7'd6, 7'd10, 7'd18, 7'd22, 7'd26, 7'd30, 7'd42};

  localparam logic [WORD_W-1:0] W_DSET = 7'd12;
  localparam logic [WORD_W-1:0] W_DCLR = 7'd13;
  localparam logic [WORD_W-1:0] W_DATA = 7'd14;
  localparam logic [WORD_W-1:0] W_PINS = 7'd15;
  localparam logic [WORD_W-1:0] W_EVT  = 7'd19;

  typedef enum logic [2:0] {RD_NONE, RD_ATTR, RD_DATA, RD_PINS, RD_EVT} rd_kind_e;

  typedef struct packed {
    logic [NATTR-1:0]   setAttr;
    logic [NATTR-1:0]   clrAttr;
    logic               setData;
    logic               clrData;
    logic               putData;
    logic               clrEvt;
    rd_kind_e           rdKind;
    logic [ATTR_IW-1:0] rdAttr;
  } strobe_t;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_regbank_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [WORD_W-1:0] addr,
  output strobe_t           strb
);

  always_comb begin
    strb        = '0;
    strb.rdKind = RD_NONE;
    for (int a = 0; a < NATTR; a++) begin
      strb.setAttr[a] = wrEn && (addr == SET_WORD[a]);
      strb.clrAttr[a] = wrEn && (addr == CLR_WORD[a]);
      if (rdEn && (addr == STAT_WORD[a])) begin
        strb.rdKind = RD_ATTR;
        strb.rdAttr = ATTR_IW'(a);
      end
    end
    strb.setData = wrEn && (addr == W_DSET);
    strb.clrData = wrEn && (addr == W_DCLR);
    strb.putData = wrEn && (addr == W_DATA);
    strb.clrEvt  = rdEn && (addr == W_EVT);
    if (rdEn) begin
      if (addr == W_DATA) strb.rdKind = RD_DATA;
      if (addr == W_PINS) strb.rdKind = RD_PINS;
      if (addr == W_EVT)  strb.rdKind = RD_EVT;
    end
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_regbank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             strb,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinValid,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irq,
  output logic [NUM_PINS-1:0] evtQ,
  output logic [NUM_PINS-1:0] evtNow,
  output logic [NUM_PINS-1:0] pioQ
);

  logic [NATTR-1:0][NUM_PINS-1:0] attrQ;
  logic [NUM_PINS-1:0] dataQ;
  logic [NUM_PINS-1:0] levelQ;
  logic [NUM_PINS-1:0] knownQ;
  logic [NUM_PINS-1:0] drvQ;
  logic [NUM_PINS-1:0] eligible;
  logic [NUM_PINS-1:0] sample;
  logic [NUM_PINS-1:0] pinView;

  // one set/clear register per attribute
  for (genvar a = 0; a < NATTR; a++) begin : g_attr
    localparam logic [NUM_PINS-1:0] RST_VAL = (a == A_PIO) ? '1 : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        attrQ[a] <= RST_VAL;
      end else if (strb.setAttr[a]) begin
        attrQ[a] <= attrQ[a] | wrData;
      end else if (strb.clrAttr[a]) begin
        attrQ[a] <= attrQ[a] & ~wrData;
      end
    end
  end

  assign eligible = attrQ[A_PIO] & ~attrQ[A_OE];
  assign sample   = pinIn & pinValid;
  assign evtNow   = eligible & (sample ^ levelQ);
  assign pinView  = (levelQ & knownQ) | (attrQ[A_PULL] & ~knownQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      levelQ <= '0;
      knownQ <= '0;
      evtQ   <= '0;
    end else begin
      levelQ <= (levelQ & ~eligible) | (sample & eligible);
      knownQ <= (knownQ & ~eligible) | (pinValid & eligible);
      evtQ   <= (strb.clrEvt ? '0 : evtQ) | evtNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataQ <= '0;
      drvQ  <= '0;
    end else if (strb.setData) begin
      dataQ <= dataQ | wrData;
      drvQ  <= drvQ | (wrData & attrQ[A_OE]);
    end else if (strb.clrData) begin
      dataQ <= dataQ & ~wrData;
      drvQ  <= drvQ & ~(wrData & attrQ[A_OE]);
    end else if (strb.putData) begin
      dataQ <= (dataQ & ~attrQ[A_OWEN]) | (wrData & attrQ[A_OWEN]);
      drvQ  <= (drvQ & ~attrQ[A_OWEN]) | (wrData & attrQ[A_OWEN]);
    end
  end

  always_comb begin
    unique case (strb.rdKind)
      RD_ATTR: rdData = attrQ[strb.rdAttr];
      RD_DATA: rdData = dataQ;
      RD_PINS: rdData = pinView;
      RD_EVT:  rdData = evtQ;
      default: rdData = '0;
    endcase
  end

  assign pinOut = drvQ;
  assign pinOe  = attrQ[A_OE];
  assign pioQ   = attrQ[A_PIO];
  assign irq    = |(evtQ & attrQ[A_IMSK]);

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [WORD_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinValid,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irq
);

  strobe_t             strb;
  logic [NUM_PINS-1:0] evtQ;
  logic [NUM_PINS-1:0] evtNow;
  logic [NUM_PINS-1:0] pioQ;

  gpio_ctrl u_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  gpio_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wrData   (wrData),
    .pinIn    (pinIn),
    .pinValid (pinValid),
    .rdData   (rdData),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irq      (irq),
    .evtQ     (evtQ),
    .evtNow   (evtNow),
    .pioQ     (pioQ)
  );

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
  import gpio_regbank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wrEn,
  input logic                rdEn,
  input logic [WORD_W-1:0]   addr,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe,
  input logic                irq,
  input logic [NUM_PINS-1:0] evtQ,
  input logic [NUM_PINS-1:0] evtNow,
  input logic [NUM_PINS-1:0] pioQ
);

  // R5: set/clear of output data moves pinOut only on output-enabled bits
  assert_set_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && (addr == W_DSET || addr == W_DCLR)) |=> ((pinOut ^ $past(pinOut)) & ~$past(pinOe)) == '0);

  // R8: new status bits only appear on eligible pins
  assert_evt_eligible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evtQ & ~$past(evtQ)) & ~($past(pioQ) & ~$past(pinOe))) == '0);

  // R10: status read with no new event leaves nothing set and irq low
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && addr == W_EVT && evtNow == '0) |=> (evtQ == '0 && !irq));

  // R11: an event on the same edge as a clearing read survives
  assert_evt_survives_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (evtNow != '0) |=> ((evtQ & $past(evtNow)) == $past(evtNow)));

  // R12: writes above the last mapped word leave the driven pins alone
  assert_unmapped_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr > 7'd42) |=> $stable(pinOut));

endmodule

bind gpio_regbank gpio_regbank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .addr   (addr),
  .pinOut (pinOut),
  .pinOe  (pinOe),
  .irq    (irq),
  .evtQ   (evtQ),
  .evtNow (evtNow),
  .pioQ   (pioQ)
);

// File: tb/test_gpio_regbank.sv
`timescale 1ns/100ps
module test_gpio_regbank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] pinIn = '0;
  logic [31:0] pinValid = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  gpio_regbank i_gpio_regbank (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .pinValid(pinValid),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  // bench view of attributes: pio, oe, filt, imsk, mdrv, pull, psel, owen
  logic [6:0]  setW [8] = '{7'd0, 7'd4, 7'd8, 7'd16, 7'd20, 7'd25, 7'd29, 7'd40};
  logic [6:0]  clrW [8] = '{7'd1, 7'd5, 7'd9, 7'd17, 7'd21, 7'd24, 7'd28, 7'd41};
  logic [6:0]  staW [8] = '{7'd2, 7'd6, 7'd10, 7'd18, 7'd22, 7'd26, 7'd30, 7'd42};
  logic [31:0] mAttr [8];
  logic [31:0] mData, mDrv, got;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic readAll(input string req);
    logic [31:0] v;
    for (int k = 0; k < 8; k++) begin
      rd(staW[k], v);
      check(req, v, mAttr[k]);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    for (int k = 0; k < 8; k++) mAttr[k] = '0;
    mAttr[0] = 32'hFFFF_FFFF;
    mData = '0; mDrv = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    readAll("R1");
    rd(7'd14, got); check("R1 data", got, 32'h0);
    rd(7'd15, got); check("R1 pins", got, 32'h0);
    rd(7'd19, got); check("R1 events", got, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 pinOut", pinOut, 32'h0);

    // R2 walking sweep over the plain attributes
    for (int k = 0; k < 8; k++) begin
      if (k == 5 || k == 6) continue;
      for (int b = 0; b < 32; b++) begin
        wr(setW[k], 32'h1 << b);
        mAttr[k] |= 32'h1 << b;
        rd(staW[k], got); check("R2 set", got, mAttr[k]);
      end
      wr(clrW[k], 32'h5A5A_C3C3);
      mAttr[k] &= ~32'h5A5A_C3C3;
      rd(staW[k], got); check("R2 clear", got, mAttr[k]);
      wr(clrW[k], 32'hFFFF_FFFF);
      mAttr[k] = '0;
      rd(staW[k], got); check("R2 clear all", got, 32'h0);
    end
    wr(setW[0], 32'hFFFF_FFFF); mAttr[0] = 32'hFFFF_FFFF;
    rd(7'd19, got); check("R2 no stray events", got, 32'h0);

    // R3 pull-up with swapped words
    wr(7'd25, 32'h0000_FFFF); mAttr[5] |= 32'h0000_FFFF;
    rd(7'd26, got); check("R3 set", got, mAttr[5]);
    wr(7'd24, 32'h00FF_00FF); mAttr[5] &= ~32'h00FF_00FF;
    rd(7'd26, got); check("R3 clear", got, mAttr[5]);
    rd(7'd15, got); check("R7 unknown pins show pull-up", got, mAttr[5]);

    // R4 peripheral select
    wr(7'd29, 32'hF0F0_F0F0); mAttr[6] |= 32'hF0F0_F0F0;
    rd(7'd30, got); check("R4 select B", got, mAttr[6]);
    wr(7'd28, 32'h3000_0030); mAttr[6] &= ~32'h3000_0030;
    rd(7'd30, got); check("R4 select A", got, mAttr[6]);

    // R7 / R8 sampled levels and change events
    @(negedge clk); pinValid = 32'hFFFF_0000; pinIn = 32'h1234_0000;
    @(negedge clk);
    rd(7'd15, got); check("R7 mixed known/unknown", got, (32'h1234_0000 & 32'hFFFF_0000) | (mAttr[5] & 32'h0000_FFFF));
    rd(7'd19, got); check("R8 rising events", got, 32'h1234_0000);
    rd(7'd19, got); check("R10 cleared", got, 32'h0);

    // R9 masked interrupt
    wr(7'd16, 32'h0004_0000); mAttr[3] = 32'h0004_0000;
    check("R9 irq idle", {31'b0, irq}, 32'h0);
    @(negedge clk); pinIn = 32'h1230_0000;
    @(negedge clk);
    check("R9 irq on masked event", {31'b0, irq}, 32'h1);
    rd(7'd19, got); check("R10 returns event", got, 32'h0004_0000);
    check("R10 irq drops", {31'b0, irq}, 32'h0);

    // unmasked event must not raise irq
    @(negedge clk); pinIn = 32'h1231_0000;
    @(negedge clk);
    check("R9 unmasked no irq", {31'b0, irq}, 32'h0);
    rd(7'd19, got); check("R8 falling/rising event", got, 32'h0001_0000);

    // R8 ineligible pins: bit20 output, bit21 peripheral-owned
    wr(7'd4, 32'h0010_0000); mAttr[1] = 32'h0010_0000;
    wr(7'd1, 32'h0020_0000); mAttr[0] &= ~32'h0020_0000;
    @(negedge clk); pinIn = 32'h1201_0000;
    @(negedge clk);
    rd(7'd19, got); check("R8 ineligible no event", got, 32'h0);
    rd(7'd15, got); check("R8 ineligible level held", got, 32'h1231_0000 | (mAttr[5] & 32'h0000_FFFF));

    // R11 read and event on the same edge
    @(negedge clk);
    rdEn = 1'b1; addr = 7'd19; pinIn = 32'h1200_0000;
    #1 got = rdData;
    @(negedge clk); rdEn = 1'b0;
    check("R11 read before event", got, 32'h0);
    rd(7'd19, got); check("R11 event kept", got, 32'h0001_0000);

    // R7 pin goes undriven -> pull-up
    @(negedge clk); pinValid = 32'hFFFE_0000;
    @(negedge clk);
    rd(7'd15, got); check("R7 pin back to unknown", got, 32'h1230_0000 | (mAttr[5] & 32'h0001_FFFF));
    rd(7'd19, got); check("R7 undriven no level change", got, 32'h0);

    // R5 set/clear output data
    wr(7'd4, 32'h0000_00FF); mAttr[1] |= 32'h0000_00FF;
    check("R5 pinOe", pinOe, mAttr[1]);
    wr(7'd12, 32'h0000_FFFF); mData |= 32'h0000_FFFF; mDrv |= 32'h0000_FFFF & mAttr[1];
    rd(7'd14, got); check("R5 data set", got, mData);
    check("R5 pinOut set", pinOut, mDrv);
    wr(7'd13, 32'h0000_000F); mData &= ~32'h0000_000F; mDrv &= ~(32'h0000_000F & mAttr[1]);
    rd(7'd14, got); check("R5 data clear", got, mData);
    check("R5 pinOut clear", pinOut, mDrv);

    // R6 masked direct write
    wr(7'd40, 32'h0F0F_0F0F); mAttr[7] = 32'h0F0F_0F0F;
    wr(7'd14, 32'hAAAA_AAAA);
    mData = (mData & ~mAttr[7]) | (32'hAAAA_AAAA & mAttr[7]);
    mDrv  = (mDrv  & ~mAttr[7]) | (32'hAAAA_AAAA & mAttr[7]);
    rd(7'd14, got); check("R6 data", got, mData);
    check("R6 pinOut", pinOut, mDrv);
    wr(7'd14, 32'h5555_5555);
    mData = (mData & ~mAttr[7]) | (32'h5555_5555 & mAttr[7]);
    mDrv  = (mDrv  & ~mAttr[7]) | (32'h5555_5555 & mAttr[7]);
    rd(7'd14, got); check("R6 data again", got, mData);
    check("R6 pinOut again", pinOut, mDrv);

    // R12 unmapped / status-only writes and reads
    wr(7'd3, 32'hFFFF_FFFF);
    wr(7'd127, 32'hFFFF_FFFF);
    wr(7'd2, 32'h0);
    wr(7'd42, 32'hFFFF_FFFF);
    wr(7'd26, 32'hFFFF_FFFF);
    readAll("R12 state kept");
    rd(7'd14, got); check("R12 data kept", got, mData);
    check("R12 pinOut kept", pinOut, mDrv);
    rd(7'd3, got);  check("R12 unmapped read", got, 32'h0);
    rd(7'd0, got);  check("R12 write-only read", got, 32'h0);
    rd(7'd12, got); check("R12 write-only read", got, 32'h0);
    rd(7'd100, got); check("R12 high unmapped read", got, 32'h0);

    finishRun();
  end

endmodule